// File: doc/BRIEF.md
# Single-wire slave slot timing engine

This block is the physical layer of a slave on a single-wire, open-drain serial bus. It runs on a system clock. A parameter gives the number of clock cycles in one microsecond, and a divider built from it provides a microsecond time base. The raw line level passes through a two-flop synchronizer and a glitch filter. The block then measures how long each low period lasts, counted from the master's falling edge.

The block handles every master-initiated slot.
- **Ordinary slot:** the block samples the line at a fixed point and reports the bit.
- **Transmitted zero:** when the upper layer asks for a zero, the block holds the line low for a short time.
- **Long low period:** when the low time is long enough, the block flags a bus reset and then answers with a presence pulse.

Two timing sets exist, regular and fast, picked by the speed input. A low period of the long regular-reset length also tells the upper layer to go back to regular speed. A shorter reset seen at fast speed leaves fast speed in place.

Top module: `owire_slot_phy`

## Requirements
- R1: After synchronous reset, and while `rst` is high, `pull_o`, `rst_det_o`, `rst_long_o` and `bit_stb_o` are all 0. Asserting `rst` during a presence pulse releases the line on the next cycle.
- R2: The line input passes through a two-flop synchronizer and a filter that accepts a new level only after `FILT_LEN` consecutive equal samples. A low glitch shorter than `FILT_LEN` cycles starts no slot.
- R3: In every slot the line is sampled once, 30 µs after the detected falling edge at regular speed (`od_i`=0) or 3 µs after it at fast speed (`od_i`=1). `bit_stb_o` pulses for one cycle, and `bit_val_o` carries the sampled level (1 = line high).
- R4: `tx_bit_i` is captured at the falling edge. A captured 0 makes `pull_o` high for 15 µs (regular) or 2 µs (fast) from the detected edge. A captured 1 leaves `pull_o` low.
- R5: At regular speed, a low period of at least 480 µs gives a one-cycle `rst_det_o` pulse when the line rises. A shorter low period gives no reset indication.
- R6: At fast speed, a low period of at least 48 µs is treated as a reset. A shorter one is not.
- R7: `rst_long_o` is high together with `rst_det_o` exactly when the low period was at least 480 µs, at either speed. A fast-speed reset between 48 and 479 µs leaves it 0.
- R8: After a reset, the block waits 30 µs from the rising edge and then drives `pull_o` for 120 µs. The fast-speed figures, 3 µs and 12 µs, apply only when the slot was at fast speed and `rst_long_o` stayed 0.
- R9: `pull_o` is high only during a presence pulse or a transmitted zero.
- R10: `rst_det_o` and `bit_stb_o` each last one cycle and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw bus level (asynchronous) |
| od_i | input | 1 | Speed select: 1 = fast timing |
| tx_bit_i | input | 1 | Bit to send in the next slot (1 = leave line alone) |
| pull_o | output | 1 | Open-drain pull-down enable |
| rst_det_o | output | 1 | Bus reset seen (one-cycle strobe) |
| rst_long_o | output | 1 | With `rst_det_o`: reset long enough to force regular speed |
| bit_stb_o | output | 1 | Slot sampled (one-cycle strobe) |
| bit_val_o | output | 1 | Sampled line level, valid with `bit_stb_o` |

## Verification
The embedded properties check the following on every cycle:
- the two strobes are exclusive and last one cycle;
- a long-reset flag appears only with a reset strobe;
- the line stays released while waiting to start a presence pulse;
- no pull occurs in a slot whose captured bit is a one;
- a change of the filtered line follows the synchronized input;
- the microsecond count saturates.

The following behaviour depends on absolute durations and on the speed in force, so only the bench scenarios can show it:
- that the sample point lands on the correct side of the write-one and write-zero low times;
- which threshold separates a slot from a reset at each speed;
- that a fast-speed short reset keeps fast presence timing while a long one reverts to regular timing;
- the lengths of the presence pulse and of the held zero.

// File: rtl/owsp_pkg.sv
package owsp_pkg;

  localparam int US_W = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_PDW, ST_PDL} ph_t;

  typedef struct packed {
    logic [US_W-1:0] smp;      // sample point after fall
    logic [US_W-1:0] hold;     // zero-bit hold time
    logic [US_W-1:0] rst_min;  // minimum low time for a reset
    logic [US_W-1:0] pd_wait;  // delay before presence
    logic [US_W-1:0] pd_low;   // presence length
  } tset_t;

  localparam logic [US_W-1:0] RST_LONG_US = US_W'(480);

  function automatic tset_t tset(input logic fast);
    tset_t t;
    if (fast) begin
      t.smp = US_W'(3);  t.hold = US_W'(2);  t.rst_min = US_W'(48);
      t.pd_wait = US_W'(3); t.pd_low = US_W'(12);
    end else begin
      t.smp = US_W'(30); t.hold = US_W'(15); t.rst_min = US_W'(480);
      t.pd_wait = US_W'(30); t.pd_low = US_W'(120);
    end
    return t;
  endfunction

endpackage

// File: rtl/owsp_linefilt.sv
module owsp_linefilt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_f
);
  logic s1, s2;
  logic [FILT_LEN-1:0] hist;
  logic all1, all0;

  assign all1 = &hist;
  assign all0 = ~|hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      hist   <= '1;
      line_f <= 1'b1;
    end else begin
      s1   <= line_i;
      s2   <= s1;
      hist <= {hist[FILT_LEN-2:0], s2};
      if (all1)      line_f <= 1'b1;
      else if (all0) line_f <= 1'b0;
    end
  end

  // R2
  filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_f) |-> ($past(s2) == line_f));

endmodule

// File: rtl/owsp_us_timer.sv
module owsp_us_timer #(
  parameter int CLK_PER_US = 125,
  parameter int W          = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] us
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PMAX = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre <= '0;
      us  <= '0;
    end else if (pre == PMAX) begin
      pre <= '0;
      if (us != '1) us <= us + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R5 (long low periods must not wrap the measurement)
  us_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (us == '1 && !clr) |=> (us == '1));

endmodule

// File: rtl/owsp_slot_ctrl.sv
module owsp_slot_ctrl
  import owsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            line_f,
  input  logic            od_i,
  input  logic            tx_bit_i,
  input  logic [US_W-1:0] us,
  output logic            tmr_clr,
  output logic            pull_o,
  output logic            rst_det_o,
  output logic            rst_long_o,
  output logic            bit_stb_o,
  output logic            bit_val_o
);
  ph_t             state, nxt;
  logic            line_q, fall, rise;
  logic            slot_fast, pd_fast, tx0, sampled;
  logic [US_W-1:0] low_len, eff_len;
  tset_t           ts, pts;
  logic            is_rst, is_long;

  assign fall    = line_q & ~line_f;
  assign rise    = ~line_q & line_f;
  assign ts      = tset(slot_fast);
  assign pts     = tset(pd_fast);
  assign eff_len = rise ? us : low_len;
  assign is_rst  = (eff_len >= ts.rst_min);
  assign is_long = (eff_len >= RST_LONG_US);

  always_comb begin
    nxt     = state;
    tmr_clr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        if (fall) nxt = ST_SLOT;
      end
      ST_SLOT: begin
        if (sampled && line_f) begin
          nxt     = is_rst ? ST_PDW : ST_IDLE;
          tmr_clr = 1'b1;
        end
      end
      ST_PDW: begin
        if (us >= pts.pd_wait) begin
          nxt     = ST_PDL;
          tmr_clr = 1'b1;
        end
      end
      ST_PDL: begin
        if (us >= pts.pd_low) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      line_q     <= 1'b1;
      slot_fast  <= 1'b0;
      pd_fast    <= 1'b0;
      tx0        <= 1'b0;
      sampled    <= 1'b0;
      low_len    <= '0;
      pull_o     <= 1'b0;
      rst_det_o  <= 1'b0;
      rst_long_o <= 1'b0;
      bit_stb_o  <= 1'b0;
      bit_val_o  <= 1'b1;
    end else begin
      state      <= nxt;
      line_q     <= line_f;
      rst_det_o  <= 1'b0;
      rst_long_o <= 1'b0;
      bit_stb_o  <= 1'b0;
      pull_o     <= (state == ST_PDL) ||
                    (state == ST_SLOT && tx0 && us < ts.hold);
      if (state == ST_IDLE && fall) begin
        slot_fast <= od_i;
        tx0       <= ~tx_bit_i;
        sampled   <= 1'b0;
        low_len   <= '0;
      end
      if (state == ST_SLOT) begin
        if (rise) low_len <= us;
        if (!sampled && us >= ts.smp) begin
          sampled   <= 1'b1;
          bit_stb_o <= 1'b1;
          bit_val_o <= line_f;
        end
        if (sampled && line_f && is_rst) begin
          rst_det_o  <= 1'b1;
          rst_long_o <= is_long;
          pd_fast    <= slot_fast & ~is_long;
        end
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rst_det_o && bit_stb_o));
  // R3
  bit_once_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb_o |=> !bit_stb_o);
  // R7
  long_needs_rst_chk: assert property (@(posedge clk) disable iff (rst)
    rst_long_o |-> rst_det_o);
  // R8
  presence_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rst_det_o |-> (state == ST_PDW));
  // R9
  pd_wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PDW && $past(state) == ST_PDW) |-> !pull_o);
  // R4
  tx1_no_pull_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLOT && $past(state) == ST_SLOT && !tx0) |-> !pull_o);

endmodule

// File: rtl/owire_slot_phy.sv
module owire_slot_phy
  import owsp_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int FILT_LEN   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic od_i,
  input  logic tx_bit_i,
  output logic pull_o,
  output logic rst_det_o,
  output logic rst_long_o,
  output logic bit_stb_o,
  output logic bit_val_o
);
  logic            line_f;
  logic            tmr_clr;
  logic [US_W-1:0] us;

  owsp_linefilt #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .line_i(line_i), .line_f(line_f)
  );

  owsp_us_timer #(.CLK_PER_US(CLK_PER_US), .W(US_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .us(us)
  );

  owsp_slot_ctrl u_ctrl (
    .clk(clk), .rst(rst), .line_f(line_f), .od_i(od_i), .tx_bit_i(tx_bit_i),
    .us(us), .tmr_clr(tmr_clr), .pull_o(pull_o), .rst_det_o(rst_det_o),
    .rst_long_o(rst_long_o), .bit_stb_o(bit_stb_o), .bit_val_o(bit_val_o)
  );

endmodule

// File: tb/test_owire_slot_phy.sv
`timescale 1ns/1ps
module test_owire_slot_phy;
  localparam int CPU  = 8;
  localparam int FILT = 3;

  typedef struct packed {
    logic       od;
    logic [15:0] low_us;
    logic       tx;
    logic [1:0] nbit;
    logic       bval;
    logic       rstx;
    logic       lng;
    logic [7:0] wait_us;
    logic [7:0] pull_us;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd5,   1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 8'd0,  8'd0},
    '{1'b0, 16'd70,  1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0},
    '{1'b0, 16'd2,   1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 8'd0,  8'd15},
    '{1'b1, 16'd1,   1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 8'd0,  8'd0},
    '{1'b1, 16'd8,   1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0},
    '{1'b1, 16'd1,   1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 8'd0,  8'd2},
    '{1'b0, 16'd500, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 8'd30, 8'd120},
    '{1'b1, 16'd60,  1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 8'd3,  8'd12},
    '{1'b1, 16'd500, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 8'd30, 8'd120},
    '{1'b0, 16'd300, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0},
    '{1'b1, 16'd40,  1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_low = 1'b0;
  logic od_i = 1'b0;
  logic tx_bit_i = 1'b1;
  logic line;
  logic pull_o, rst_det_o, rst_long_o, bit_stb_o, bit_val_o;

  always #4 clk = ~clk;

  assign line = ~(master_low | pull_o);

  owire_slot_phy #(.CLK_PER_US(CPU), .FILT_LEN(FILT)) i_owire_slot_phy (
    .clk(clk), .rst(rst), .line_i(line), .od_i(od_i), .tx_bit_i(tx_bit_i),
    .pull_o(pull_o), .rst_det_o(rst_det_o), .rst_long_o(rst_long_o),
    .bit_stb_o(bit_stb_o), .bit_val_o(bit_val_o)
  );

  int cyc = 0, n_bit = 0, n_rst = 0, n_pull = 0, n_both = 0;
  int pull_rise = 0, pull_fall = 0;
  logic last_val = 1'b0, last_long = 1'b0, pull_prev = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bit_stb_o) begin n_bit <= n_bit + 1; last_val <= bit_val_o; end
    if (rst_det_o) begin n_rst <= n_rst + 1; last_long <= rst_long_o; end
    if (bit_stb_o && rst_det_o) n_both <= n_both + 1;
    if (pull_o && !pull_prev) begin n_pull <= n_pull + 1; pull_rise <= cyc; end
    if (!pull_o && pull_prev) pull_fall <= cyc;
    pull_prev <= pull_o;
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !done) begin
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_rng(input int act, input int e);
    return (act >= (e - 1) * CPU) && (act <= (e + 1) * CPU + 8);
  endfunction

  initial begin
    int b0, r0, p0, rel;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(pull_o == 1'b0 && rst_det_o == 1'b0 && bit_stb_o == 1'b0 && rst_long_o == 1'b0,
        "R1 reset outputs", {pull_o, rst_det_o, bit_stb_o}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      od_i = VECS[v].od;
      tx_bit_i = VECS[v].tx;
      b0 = n_bit; r0 = n_rst; p0 = n_pull;
      @(negedge clk);
      master_low = 1'b1;
      repeat (int'(VECS[v].low_us) * CPU) @(negedge clk);
      master_low = 1'b0;
      rel = cyc;
      tx_bit_i = 1'b1;
      repeat (200 * CPU) @(negedge clk);
      // R3 sampled bit
      chk(n_bit - b0 == int'(VECS[v].nbit), "R3 bit count", n_bit - b0, VECS[v].nbit);
      chk(last_val == VECS[v].bval, "R3 bit value", last_val, VECS[v].bval);
      // R5 / R6 reset detection
      chk(n_rst - r0 == int'(VECS[v].rstx), VECS[v].od ? "R6 reset" : "R5 reset",
          n_rst - r0, VECS[v].rstx);
      if (VECS[v].rstx) begin
        chk(last_long == VECS[v].lng, "R7 long flag", last_long, VECS[v].lng);
        chk(n_pull - p0 == 1, "R8 presence count", n_pull - p0, 1);
        chk(in_rng(pull_rise - rel, VECS[v].wait_us), "R8 presence wait",
            pull_rise - rel, VECS[v].wait_us * CPU);
        chk(in_rng(pull_fall - pull_rise, VECS[v].pull_us), "R8 presence length",
            pull_fall - pull_rise, VECS[v].pull_us * CPU);
      end else if (VECS[v].pull_us != 0) begin
        chk(n_pull - p0 == 1, "R4 zero hold count", n_pull - p0, 1);
        chk(in_rng(pull_fall - pull_rise, VECS[v].pull_us), "R4 zero hold length",
            pull_fall - pull_rise, VECS[v].pull_us * CPU);
      end else begin
        chk(n_pull - p0 == 0, "R9 no pull", n_pull - p0, 0);
      end
    end

    // R2 glitch shorter than the filter
    b0 = n_bit; r0 = n_rst; p0 = n_pull;
    od_i = 1'b1;
    master_low = 1'b1;
    repeat (FILT - 1) @(negedge clk);
    master_low = 1'b0;
    repeat (50 * CPU) @(negedge clk);
    chk(n_bit == b0 && n_rst == r0 && n_pull == p0, "R2 glitch ignored", n_bit - b0, 0);

    // R1 reset during presence
    od_i = 1'b0;
    master_low = 1'b1;
    repeat (500 * CPU) @(negedge clk);
    master_low = 1'b0;
    repeat (60 * CPU) @(negedge clk);
    chk(pull_o == 1'b1, "R8 presence active", pull_o, 1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(pull_o == 1'b0, "R1 reset releases line", pull_o, 0);
    rst = 1'b0;
    repeat (200 * CPU) @(negedge clk);

    // R10 strobes never coincide
    chk(n_both == 0, "R10 strobe overlap", n_both, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule